// File: doc/BRIEF.md
# Programmable Raster Sync Timing Generator

This block produces the horizontal and vertical timing for a raster display from a single pixel clock. A pixel counter and a line counter sweep each frame. From them the block decodes the display-enable window, the horizontal and vertical sync pulses and a flag that marks vertical retrace. A host sets the timing through a small write-only register port. Horizontal quantities are programmed in groups of eight pixels and vertical quantities in lines. Each value is stored as its count minus one.

The line length is the active width plus the horizontal non-display width. The frame height is the active height plus the vertical non-display height. A sync pulse begins a programmed front porch after the end of the active region. Writes go first to a shadow copy. That copy becomes the working timing only when the last pixel of a frame rolls over, so the frame being scanned is never disturbed. A polarity bit and a panel-kind bit together choose the asserted level of each sync. A blank bit holds display-enable low while the sync pulses keep running.

Top module: `vtg_top`

## Requirements
- R1: A synchronous active-high reset clears `pix_x` and `line_y` to zero and loads the working and shadow timing from the module parameters (blank and panel-kind cleared).
- R2: `pix_x` rises by one every clock and returns to 0 after the value 8*(HACT+1) + 8*(HNDP+1) - 1.
- R3: `line_y` rises by one when `pix_x` wraps and returns to 0 after the value (VACT+1) + (VNDP+1) - 1; it holds otherwise.
- R4: `de` is 1 exactly when `pix_x` < 8*(HACT+1), `line_y` < VACT+1 and blank is 0.
- R5: The horizontal sync is asserted for `pix_x` in [A + 8*(HSS+1), A + 8*(HSS+1) + 8*(HSW+1)), where A = 8*(HACT+1).
- R6: The vertical sync is asserted for whole lines with `line_y` in [B + VSS + 1, B + VSS + 1 + VSW + 1), where B = VACT+1.
- R7: A sync is asserted high when (its polarity bit XOR panel-kind) is 1 and asserted low otherwise, with the opposite level outside the pulse. So polarity 1 gives an active-high pulse on a CRT/TFT panel (panel-kind 0) and an active-low pulse on a passive panel (panel-kind 1).
- R8: `vretrace` is 1 exactly when `line_y` >= VACT+1.
- R9: With blank set, `de` stays 0 for the whole frame while both sync outputs follow R5 to R7 unchanged.
- R10: A register write changes the shadow copy only. The working timing takes the shadow value, including a write made in that same cycle, on the clock edge where `pix_x` and `line_y` both wrap, and at no other edge.
- R11: Register map on `wr_addr` with fields in the low bits of `wr_data`: 0 HACT[7:0], 1 HNDP[7:0], 2 HSS[7:0], 3 HSW[3:0] with horizontal polarity at bit 7, 4 VACT[9:0], 5 VNDP[9:0], 6 VSS[9:0], 7 VSW[3:0] with vertical polarity at bit 7, 8 control: bit 0 blank, bit 1 panel-kind. Writes to any other address change nothing.
- R12: HACT=0x4F with HNDP=0x17 gives an 832-pixel line and with HNDP=0x13 an 800-pixel line. VNDP=0x27 gives 40 non-display lines and VNDP=0x2C gives 45.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register select |
| wr_data | input | 10 | Register write value |
| pix_x | output | 13 | Pixel position within the line |
| line_y | output | 12 | Line position within the frame |
| hsync | output | 1 | Horizontal sync at programmed level |
| vsync | output | 1 | Vertical sync at programmed level |
| de | output | 1 | Display enable |
| vretrace | output | 1 | High during vertical non-display lines |

## Verification
The in-design checks that place each sync pulse inside its non-display span hold only when the programmed front porch plus pulse width fits inside the non-display width, that is (HSS+1)+(HSW+1) <= HNDP+1 and (VSS+1)+(VSW+1) <= VNDP+1. They also assume the 8-pixel horizontal units and line units never push a pulse past the end of its line or frame. Every timing set the bench programs, including the reduced-height variants of the 832- and 800-pixel lines, is chosen to satisfy both inequalities. The bench writes registers only between clock edges, so the working-copy hold check sees writes at clearly defined edges.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    // field widths and unit scaling
    localparam int HF_W       = 8;
    localparam int VF_W       = 10;
    localparam int PW_W       = 4;
    localparam int HUNIT_LOG2 = 3;
    localparam int ADDR_W     = 4;
    localparam int DATA_W     = VF_W;
    localparam int POL_BIT    = 7;

    // counter widths cover active + non-display + pulse overshoot
    localparam int HCNT_W = HF_W + HUNIT_LOG2 + 2;
    localparam int VCNT_W = VF_W + 2;

    // register addresses
    localparam logic [ADDR_W-1:0] A_HACT = 4'd0;
    localparam logic [ADDR_W-1:0] A_HNDP = 4'd1;
    localparam logic [ADDR_W-1:0] A_HSS  = 4'd2;
    localparam logic [ADDR_W-1:0] A_HSW  = 4'd3;
    localparam logic [ADDR_W-1:0] A_VACT = 4'd4;
    localparam logic [ADDR_W-1:0] A_VNDP = 4'd5;
    localparam logic [ADDR_W-1:0] A_VSS  = 4'd6;
    localparam logic [ADDR_W-1:0] A_VSW  = 4'd7;
    localparam logic [ADDR_W-1:0] A_CTRL = 4'd8;

    typedef struct packed {
        logic [HF_W-1:0] hact;
        logic [HF_W-1:0] hndp;
        logic [HF_W-1:0] hss;
        logic [PW_W-1:0] hsw;
        logic            hpol;
        logic [VF_W-1:0] vact;
        logic [VF_W-1:0] vndp;
        logic [VF_W-1:0] vss;
        logic [PW_W-1:0] vsw;
        logic            vpol;
        logic            blank;
        logic            passive;
    } timing_cfg_t;

    // merge one register write into a timing set
    function automatic timing_cfg_t apply_write(input timing_cfg_t cur,
                                                input logic [ADDR_W-1:0] addr,
                                                input logic [DATA_W-1:0] d);
        timing_cfg_t nxt;
        nxt = cur;
        case (addr)
            A_HACT: nxt.hact = d[HF_W-1:0];
            A_HNDP: nxt.hndp = d[HF_W-1:0];
            A_HSS:  nxt.hss  = d[HF_W-1:0];
            A_HSW: begin
                nxt.hsw  = d[PW_W-1:0];
                nxt.hpol = d[POL_BIT];
            end
            A_VACT: nxt.vact = d[VF_W-1:0];
            A_VNDP: nxt.vndp = d[VF_W-1:0];
            A_VSS:  nxt.vss  = d[VF_W-1:0];
            A_VSW: begin
                nxt.vsw  = d[PW_W-1:0];
                nxt.vpol = d[POL_BIT];
            end
            A_CTRL: begin
                nxt.blank   = d[0];
                nxt.passive = d[1];
            end
            default: ;
        endcase
        return nxt;
    endfunction

    // output level of a sync line given pulse state, polarity and panel kind
    function automatic logic sync_level(input logic in_pulse, input logic pol,
                                        input logic passive);
        logic asserted_lvl;
        asserted_lvl = pol ^ passive;
        return in_pulse ? asserted_lvl : ~asserted_lvl;
    endfunction

endpackage

// File: rtl/vtg_cfg_regs.sv
module vtg_cfg_regs
    import vtg_pkg::*;
#(
    parameter timing_cfg_t RESET_CFG = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              commit,
    output timing_cfg_t       active_cfg
);

    timing_cfg_t shadow_q;
    timing_cfg_t shadow_d;
    timing_cfg_t active_q;

    always_comb begin
        shadow_d = shadow_q;
        if (wr_en) begin
            shadow_d = apply_write(shadow_q, wr_addr, wr_data);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= RESET_CFG;
            active_q <= RESET_CFG;
        end else begin
            shadow_q <= shadow_d;
            if (commit) begin
                active_q <= shadow_d;
            end
        end
    end

    assign active_cfg = active_q;

    // working timing only moves at the frame boundary
    a_r10_hold_midframe: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(active_q));

    // a commit copies the shadow state including the same-cycle write
    a_r10_commit_copies: assert property (@(posedge clk) disable iff (rst)
        commit |=> (active_q == shadow_q));

endmodule

// File: rtl/vtg_axis.sv
module vtg_axis #(
    parameter int FIELD_W   = 8,
    parameter int PW_W      = 4,
    parameter int UNIT_LOG2 = 3,
    parameter int CNT_W     = FIELD_W + UNIT_LOG2 + 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               adv,
    input  logic [FIELD_W-1:0] act_u,
    input  logic [FIELD_W-1:0] ndp_u,
    input  logic [FIELD_W-1:0] ss_u,
    input  logic [PW_W-1:0]    sw_u,
    output logic [CNT_W-1:0]   cnt,
    output logic               last,
    output logic               in_act,
    output logic               in_pulse
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] act_len;
    logic [CNT_W-1:0] ndp_len;
    logic [CNT_W-1:0] fp_len;
    logic [CNT_W-1:0] sw_len;
    logic [CNT_W-1:0] total_m1;
    logic [CNT_W-1:0] p_on;
    logic [CNT_W-1:0] p_off;
    logic [CNT_W-1:0] cnt_q;

    // minus-one fields to lengths, scaled to the axis unit
    generate
        if (UNIT_LOG2 == 0) begin : g_line_units
            assign act_len = CNT_W'(act_u) + ONE;
            assign ndp_len = CNT_W'(ndp_u) + ONE;
            assign fp_len  = CNT_W'(ss_u) + ONE;
            assign sw_len  = CNT_W'(sw_u) + ONE;
        end else begin : g_group_units
            assign act_len = (CNT_W'(act_u) + ONE) << UNIT_LOG2;
            assign ndp_len = (CNT_W'(ndp_u) + ONE) << UNIT_LOG2;
            assign fp_len  = (CNT_W'(ss_u) + ONE) << UNIT_LOG2;
            assign sw_len  = (CNT_W'(sw_u) + ONE) << UNIT_LOG2;
        end
    endgenerate

    assign total_m1 = act_len + ndp_len - ONE;
    assign p_on     = act_len + fp_len;
    assign p_off    = p_on + sw_len;

    assign last     = (cnt_q == total_m1);
    assign in_act   = (cnt_q < act_len);
    assign in_pulse = (cnt_q >= p_on) && (cnt_q < p_off);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= last ? '0 : cnt_q + ONE;
        end
    end

    assign cnt = cnt_q;

    // R2 for the pixel axis, R3 for the line axis
    a_r2_r3_step: assert property (@(posedge clk) disable iff (rst)
        (adv && !last) |=> (cnt_q == $past(cnt_q) + ONE));

    a_r2_r3_wrap: assert property (@(posedge clk) disable iff (rst)
        (adv && last) |=> (cnt_q == '0));

    a_r2_r3_hold: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(cnt_q));

endmodule

// File: rtl/vtg_out.sv
module vtg_out
    import vtg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic h_act,
    input  logic v_act,
    input  logic h_pulse,
    input  logic v_pulse,
    input  logic hpol,
    input  logic vpol,
    input  logic passive,
    input  logic blank,
    output logic hsync,
    output logic vsync,
    output logic de,
    output logic vretrace
);

    always_comb begin
        hsync    = sync_level(h_pulse, hpol, passive);
        vsync    = sync_level(v_pulse, vpol, passive);
        de       = h_act & v_act & ~blank;
        vretrace = ~v_act;
    end

    a_r8_retrace_no_de: assert property (@(posedge clk) disable iff (rst)
        vretrace |-> !de);

    a_r9_blank_no_de: assert property (@(posedge clk) disable iff (rst)
        blank |-> !de);

    a_r7_hsync_level: assert property (@(posedge clk) disable iff (rst)
        !h_pulse |-> (hsync == ~(hpol ^ passive)));

endmodule

// File: rtl/vtg_top.sv
module vtg_top
    import vtg_pkg::*;
#(
    parameter int P_HACT = 79,
    parameter int P_HNDP = 19,
    parameter int P_HSS  = 1,
    parameter int P_HSW  = 11,
    parameter int P_HPOL = 0,
    parameter int P_VACT = 479,
    parameter int P_VNDP = 44,
    parameter int P_VSS  = 9,
    parameter int P_VSW  = 1,
    parameter int P_VPOL = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [HCNT_W-1:0] pix_x,
    output logic [VCNT_W-1:0] line_y,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic              vretrace
);

    localparam timing_cfg_t DEF_CFG = '{
        hact:    HF_W'(P_HACT),
        hndp:    HF_W'(P_HNDP),
        hss:     HF_W'(P_HSS),
        hsw:     PW_W'(P_HSW),
        hpol:    1'(P_HPOL),
        vact:    VF_W'(P_VACT),
        vndp:    VF_W'(P_VNDP),
        vss:     VF_W'(P_VSS),
        vsw:     PW_W'(P_VSW),
        vpol:    1'(P_VPOL),
        blank:   1'b0,
        passive: 1'b0
    };

    timing_cfg_t cfg;
    logic        h_last, v_last;
    logic        h_act, v_act;
    logic        h_pulse, v_pulse;
    logic        frame_wrap;

    assign frame_wrap = h_last & v_last;

    vtg_cfg_regs #(
        .RESET_CFG (DEF_CFG)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .commit     (frame_wrap),
        .active_cfg (cfg)
    );

    vtg_axis #(
        .FIELD_W   (HF_W),
        .PW_W      (PW_W),
        .UNIT_LOG2 (HUNIT_LOG2),
        .CNT_W     (HCNT_W)
    ) u_hax (
        .clk      (clk),
        .rst      (rst),
        .adv      (1'b1),
        .act_u    (cfg.hact),
        .ndp_u    (cfg.hndp),
        .ss_u     (cfg.hss),
        .sw_u     (cfg.hsw),
        .cnt      (pix_x),
        .last     (h_last),
        .in_act   (h_act),
        .in_pulse (h_pulse)
    );

    vtg_axis #(
        .FIELD_W   (VF_W),
        .PW_W      (PW_W),
        .UNIT_LOG2 (0),
        .CNT_W     (VCNT_W)
    ) u_vax (
        .clk      (clk),
        .rst      (rst),
        .adv      (h_last),
        .act_u    (cfg.vact),
        .ndp_u    (cfg.vndp),
        .ss_u     (cfg.vss),
        .sw_u     (cfg.vsw),
        .cnt      (line_y),
        .last     (v_last),
        .in_act   (v_act),
        .in_pulse (v_pulse)
    );

    vtg_out u_out (
        .clk      (clk),
        .rst      (rst),
        .h_act    (h_act),
        .v_act    (v_act),
        .h_pulse  (h_pulse),
        .v_pulse  (v_pulse),
        .hpol     (cfg.hpol),
        .vpol     (cfg.vpol),
        .passive  (cfg.passive),
        .blank    (cfg.blank),
        .hsync    (hsync),
        .vsync    (vsync),
        .de       (de),
        .vretrace (vretrace)
    );

    // sync pulses stay inside their non-display spans (legal programming)
    a_r5_hsync_in_porch: assert property (@(posedge clk) disable iff (rst)
        h_pulse |-> !h_act);

    a_r6_vsync_in_porch: assert property (@(posedge clk) disable iff (rst)
        v_pulse |-> !v_act);

    // lines advance only as the pixel counter wraps
    a_r3_line_moves_on_wrap: assert property (@(posedge clk) disable iff (rst)
        !h_last |=> $stable(line_y));

endmodule

// File: tb/vtg_top_bench.sv
module vtg_top_bench;
    import vtg_pkg::*;

    localparam int TB_HACT = 1, TB_HNDP = 2, TB_HSS = 0, TB_HSW = 0, TB_HPOL = 0;
    localparam int TB_VACT = 2, TB_VNDP = 3, TB_VSS = 0, TB_VSW = 1, TB_VPOL = 0;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [HCNT_W-1:0] pix_x;
    logic [VCNT_W-1:0] line_y;
    logic              hsync, vsync, de, vretrace;

    always #10 clk = ~clk;

    vtg_top #(
        .P_HACT(TB_HACT), .P_HNDP(TB_HNDP), .P_HSS(TB_HSS), .P_HSW(TB_HSW),
        .P_HPOL(TB_HPOL), .P_VACT(TB_VACT), .P_VNDP(TB_VNDP), .P_VSS(TB_VSS),
        .P_VSW(TB_VSW), .P_VPOL(TB_VPOL)
    ) u_vtg_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pix_x(pix_x), .line_y(line_y), .hsync(hsync), .vsync(vsync),
        .de(de), .vretrace(vretrace)
    );

    typedef struct {
        int   x;
        int   y;
        logic hs;
        logic vs;
        logic en;
        logic vr;
    } exp_t;

    typedef struct {
        int ha, hn, hs, hw; logic hp;
        int va, vn, vs, vw; logic vp;
        logic bl, pk;
    } tcfg_t;

    exp_t  sb_q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 0;
    tcfg_t m_act, m_shd;
    int    mh = 0, mv = 0;

    function automatic tcfg_t tb_defaults();
        tcfg_t c;
        c.ha = TB_HACT; c.hn = TB_HNDP; c.hs = TB_HSS; c.hw = TB_HSW; c.hp = 1'(TB_HPOL);
        c.va = TB_VACT; c.vn = TB_VNDP; c.vs = TB_VSS; c.vw = TB_VSW; c.vp = 1'(TB_VPOL);
        c.bl = 1'b0; c.pk = 1'b0;
        return c;
    endfunction

    // register map as the requirements state it (R11)
    function automatic tcfg_t tb_write(tcfg_t c, int a, int d);
        tcfg_t n = c;
        if (a == 0) n.ha = d & 8'hFF;
        else if (a == 1) n.hn = d & 8'hFF;
        else if (a == 2) n.hs = d & 8'hFF;
        else if (a == 3) begin n.hw = d & 4'hF; n.hp = 1'((d >> 7) & 1); end
        else if (a == 4) n.va = d & 10'h3FF;
        else if (a == 5) n.vn = d & 10'h3FF;
        else if (a == 6) n.vs = d & 10'h3FF;
        else if (a == 7) begin n.vw = d & 4'hF; n.vp = 1'((d >> 7) & 1); end
        else if (a == 8) begin n.bl = 1'(d & 1); n.pk = 1'((d >> 1) & 1); end
        return n;
    endfunction

    function automatic int htot(tcfg_t c); return 8 * (c.ha + 1) + 8 * (c.hn + 1); endfunction
    function automatic int vtot(tcfg_t c); return (c.va + 1) + (c.vn + 1); endfunction

    function automatic exp_t expect_at(tcfg_t c, int h, int v);
        exp_t e;
        int ha_px, hs_on, hs_off, vs_on, vs_off;
        logic hpulse, vpulse, hact, vact;
        ha_px  = 8 * (c.ha + 1);
        hs_on  = ha_px + 8 * (c.hs + 1);
        hs_off = hs_on + 8 * (c.hw + 1);
        vs_on  = (c.va + 1) + c.vs + 1;
        vs_off = vs_on + c.vw + 1;
        hact   = (h < ha_px);
        vact   = (v < c.va + 1);
        hpulse = (h >= hs_on) && (h < hs_off);
        vpulse = (v >= vs_on) && (v < vs_off);
        e.x  = h;
        e.y  = v;
        e.hs = hpulse ? (c.hp ^ c.pk) : ~(c.hp ^ c.pk);
        e.vs = vpulse ? (c.vp ^ c.pk) : ~(c.vp ^ c.pk);
        e.en = hact & vact & ~c.bl;
        e.vr = ~vact;
        return e;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // driver-side model: pushes the expected outputs for each new cycle
    initial begin
        forever begin
            @(posedge clk);
            if (rst) begin
                m_act = tb_defaults();
                m_shd = tb_defaults();
                mh = 0;
                mv = 0;
            end else begin
                tcfg_t nshd;
                bit hl, vl;
                nshd = wr_en ? tb_write(m_shd, int'(wr_addr), int'(wr_data)) : m_shd;
                hl = (mh == htot(m_act) - 1);
                vl = (mv == vtot(m_act) - 1);
                mh = hl ? 0 : mh + 1;
                if (hl) mv = vl ? 0 : mv + 1;
                if (hl && vl) m_act = nshd;
                m_shd = nshd;
            end
            sb_q.push_back(expect_at(m_act, mh, mv));
        end
    end

    // monitor: compares each cycle away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check("R2 pix_x", int'(pix_x), e.x);
                check("R3 line_y", int'(line_y), e.y);
                check("R4 R9 de", int'(de), int'(e.en));
                check("R5 R7 hsync", int'(hsync), int'(e.hs));
                check("R6 R7 vsync", int'(vsync), int'(e.vs));
                check("R8 vretrace", int'(vretrace), int'(e.vr));
            end
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = ADDR_W'(a);
        wr_data = DATA_W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_frame_start();
        @(negedge clk);
        while (!(pix_x == 0 && line_y == 0)) @(negedge clk);
    endtask

    // counts from the current cycle up to (not including) the next frame start
    task automatic run_to_start(input logic hlvl, input logic vlvl,
                                output int lines, output int len0, output int de_n,
                                output int hs_n, output int vs_n, output int vr_n);
        lines = 0; len0 = 0; de_n = 0; hs_n = 0; vs_n = 0; vr_n = 0;
        do begin
            if (pix_x == 0) lines++;
            if (line_y == 0) len0++;
            if (de) de_n++;
            if (hsync == hlvl) hs_n++;
            if (vsync == vlvl) vs_n++;
            if (vretrace) vr_n++;
            @(negedge clk);
        end while (!(pix_x == 0 && line_y == 0));
    endtask

    initial begin
        int ln, l0, dn, hn, vn, rn;
        repeat (3) @(negedge clk);
        // R1: state held in reset
        check("R1 pix_x", int'(pix_x), 0);
        check("R1 line_y", int'(line_y), 0);
        check("R1 hsync idle high", int'(hsync), 1);
        check("R1 de", int'(de), 1);
        check("R1 vretrace", int'(vretrace), 0);
        rst = 1'b0;

        // R1 R12: parameter timing is in force after reset
        wait_frame_start();
        run_to_start(1'b0, 1'b0, ln, l0, dn, hn, vn, rn);
        check("R1 line length", l0, 40);
        check("R1 frame lines", ln, 7);
        check("R5 hsync low cycles", hn, 7 * 8);
        check("R6 vsync low cycles", vn, 2 * 40);

        // R10: mid-frame write leaves the current frame alone
        wait_frame_start();
        wr(3, 8'h81);
        run_to_start(1'b0, 1'b0, ln, l0, dn, hn, vn, rn);
        check("R10 old hsync width kept", hn, 7 * 8);
        run_to_start(1'b1, 1'b0, ln, l0, dn, hn, vn, rn);
        check("R11 R7 new hsync high width", hn, 7 * 16);

        // R9: blank
        wr(8, 1);
        run_to_start(1'b1, 1'b0, ln, l0, dn, hn, vn, rn);
        run_to_start(1'b1, 1'b0, ln, l0, dn, hn, vn, rn);
        check("R9 de stays low", dn, 0);
        check("R9 hsync still pulses", hn, 7 * 16);
        check("R9 vsync still pulses", vn, 2 * 40);

        // R7: passive panel flips asserted levels
        wr(8, 2);
        run_to_start(1'b1, 1'b0, ln, l0, dn, hn, vn, rn);
        run_to_start(1'b0, 1'b1, ln, l0, dn, hn, vn, rn);
        check("R7 passive hsync low width", hn, 7 * 16);
        check("R7 passive vsync high lines", vn, 2 * 40);
        check("R4 de window", dn, 3 * 16);
        check("R8 retrace cycles", rn, 4 * 40);
        wr(8, 0);

        // R11: unmapped address has no effect
        wr(9, 10'h3FF);
        wr(15, 10'h000);
        run_to_start(1'b1, 1'b0, ln, l0, dn, hn, vn, rn);
        run_to_start(1'b1, 1'b0, ln, l0, dn, hn, vn, rn);
        check("R11 unmapped line length", l0, 40);
        check("R11 unmapped frame lines", ln, 7);
        check("R11 unmapped de window", dn, 3 * 16);

        // R12: 832-pixel line, 40 non-display lines
        wr(0, 8'h4F); wr(1, 8'h17); wr(2, 3); wr(3, 4);
        wr(4, 1); wr(5, 8'h27); wr(6, 8); wr(7, 2);
        run_to_start(1'b0, 1'b0, ln, l0, dn, hn, vn, rn);
        run_to_start(1'b0, 1'b0, ln, l0, dn, hn, vn, rn);
        check("R12 line 832", l0, 832);
        check("R12 frame 2+40", ln, 42);
        check("R12 R5 hsync 40px per line", hn, 42 * 40);
        check("R12 R6 vsync 3 lines", vn, 3 * 832);

        // R12: 800-pixel line, 45 non-display lines
        wr(1, 8'h13); wr(2, 1); wr(3, 8'h0B);
        wr(5, 8'h2C); wr(6, 9); wr(7, 1);
        run_to_start(1'b0, 1'b0, ln, l0, dn, hn, vn, rn);
        run_to_start(1'b0, 1'b0, ln, l0, dn, hn, vn, rn);
        check("R12 line 800", l0, 800);
        check("R12 frame 2+45", ln, 47);
        check("R12 R5 hsync 96px per line", hn, 47 * 96);
        check("R12 R4 de window", dn, 2 * 640);

        repeat (4) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule